// File: doc/BRIEF.md
# Keyed Logical-Device Configuration Registers

This block is the configuration register file of a multi-function I/O controller. Software reaches it through two neighbouring byte addresses on an 8-bit ISA-style I/O bus: an index port that selects a register, and a data port one address above it that reads or writes that register. A static strap input places the pair at one of two fixed addresses. Writes through the data port take effect only after a key byte has been written to the index port. A second key byte locks them out again.

The register space is split in two. Indices below 0x30 reach a small set of chip-wide registers. These include a logical-device selector, a power-control byte, two masked configuration bytes, a read-only device ID and a read-only copy of the index-port address. Indices from 0x30 upward reach a bank that belongs to the logical device currently selected. Each of the four implemented devices has its own bank: floppy, parallel and two serial ports. A bank holds an activate bit, a 16-bit base address, an IRQ number and a DMA channel. The block drives these values to the peripheral decoders, together with one enable flag per device. A data write to the chip-wide soft-reset register puts the device state back to its defaults.

Top module: `ldev_cfg_regs`

## Requirements
- R1: The index port is at 0x03F0 when `alt_port_sel` is 0 and at 0x0370 when it is 1. The data port is the index port plus one. Bus accesses to any other address change nothing, and a read of one returns 0.
- R2: After reset, configuration writes are locked. Writing 0x55 to the index port unlocks them and writing 0xAA locks them again; the key byte also becomes the index. While locked, data-port writes leave every register and every output unchanged. Reads still work.
- R3: A data write to global index 0x07 selects the logical device from bit 3 to bit 0 of the byte. Device codes are 0 for floppy, 3 for parallel, 4 for serial 1 and 5 for serial 2. In the output vectors, slot 0 is floppy, slot 1 parallel, slot 2 serial 1 and slot 3 serial 2. Each device's bank is separate. Bank writes made while another code is selected are dropped, and bank reads then return 0.
- R4: Global index 0x22 (power control) keeps the written byte ANDed with 0x3F, index 0x23 keeps it ANDed with 0x3F and index 0x24 keeps it ANDed with 0xCE. Each reads back the masked value.
- R5: In a bank, index 0x30 keeps only bit 0 (activate). Index 0x60 is the high byte of the base address and 0x61 is the low byte. Index 0x70 and 0x74 store full bytes. Their low 4 bits drive the IRQ output and their low 3 bits drive the DMA output.
- R6: A data-port read returns the selected device's bank register when the index is 0x30 or above, and the global register otherwise. An unimplemented index reads 0. An index-port read returns the current index.
- R7: A device's enable output is its activate bit ORed with its power-control bit: bit 0 for floppy, bit 4 for serial 1 and bit 5 for serial 2. The parallel device is enabled only by its activate bit.
- R8: After reset, the floppy bank holds base 0x03F0, IRQ 6 and DMA 2 with activate 0, and all other banks hold zero. Index 0x20 reads 0x47 and 0x24 reads 0x04. Index 0x26 and 0x27 read the low and high nibbles of the index-port address's low byte.
- R9: An unlocked data write to index 0x02 with bit 0 set is a soft reset. In the next cycle the device selector is 0, power control is 0 and every bank holds its reset value. Index 0x02 holds the written byte, index 0x23 and 0x24 keep their values, and the lock state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_port_sel | input | 1 | Static strap: 1 places the index port at 0x0370 |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| dev_en | output | 4 | Decode enable per device |
| dev_base | output | 64 | 16-bit base address per device |
| dev_irq | output | 16 | IRQ number per device |
| dev_dma | output | 12 | DMA channel per device |

## Verification
The assertions assume that `bus_wr` lasts one clock per access and that `alt_port_sel` changes only while reset is held. The bench drives the bus on the falling edge with one-cycle write strobes, and it changes the strap only inside a reset pulse. The assertions also assume that a write and a read do not target the same port in the same cycle; the bench never overlaps them. Expected register and output values come from a reference model of the requirements kept in the bench. The stimulus sweeps every device code, all 256 byte values for the masked registers and all 64 power-control patterns.

// File: rtl/ldev_cfg_pkg.sv
package ldev_cfg_pkg;
   localparam int LDEV_COUNT = 4;
   localparam logic [7:0] KEY_OPEN  = 8'h55;
   localparam logic [7:0] KEY_CLOSE = 8'hAA;

   localparam logic [7:0] IX_SRST  = 8'h02;
   localparam logic [7:0] IX_LDN   = 8'h07;
   localparam logic [7:0] IX_ID    = 8'h20;
   localparam logic [7:0] IX_PWR   = 8'h22;
   localparam logic [7:0] IX_CFGA  = 8'h23;
   localparam logic [7:0] IX_CFGB  = 8'h24;
   localparam logic [7:0] IX_PLO   = 8'h26;
   localparam logic [7:0] IX_PHI   = 8'h27;
   localparam logic [7:0] IX_BANK  = 8'h30;
   localparam logic [7:0] IX_ACT   = 8'h30;
   localparam logic [7:0] IX_BHI   = 8'h60;
   localparam logic [7:0] IX_BLO   = 8'h61;
   localparam logic [7:0] IX_IRQ   = 8'h70;
   localparam logic [7:0] IX_DMA   = 8'h74;

   localparam logic [7:0] MASK_PWR  = 8'h3F;
   localparam logic [7:0] MASK_CFGA = 8'h3F;
   localparam logic [7:0] MASK_CFGB = 8'hCE;
   localparam logic [7:0] CHIP_ID   = 8'h47;
   localparam logic [7:0] CFGB_RST  = 8'h04;

   // slot -> logical device code
   function automatic logic [3:0] ldn_of(input int slot);
      case (slot)
         0:       return 4'd0;
         1:       return 4'd3;
         2:       return 4'd4;
         default: return 4'd5;
      endcase
   endfunction

   // slot -> power-control bit, -1 when none
   function automatic int pwr_bit_of(input int slot);
      case (slot)
         0:       return 0;
         1:       return -1;
         2:       return 4;
         default: return 5;
      endcase
   endfunction

   function automatic logic [15:0] def_base_of(input int slot);
      return (slot == 0) ? 16'h03F0 : 16'h0000;
   endfunction

   function automatic logic [7:0] def_irq_of(input int slot);
      return (slot == 0) ? 8'h06 : 8'h00;
   endfunction

   function automatic logic [7:0] def_dma_of(input int slot);
      return (slot == 0) ? 8'h02 : 8'h00;
   endfunction
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode import ldev_cfg_pkg::*; #(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] PRI_PORT = 16'h03F0,
   parameter logic [ADDR_W-1:0] ALT_PORT = 16'h0370
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alt_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [ADDR_W-1:0] port_addr,
   output logic [7:0]        idx,
   output logic              unlocked,
   output logic              data_wr,
   output logic              data_rd,
   output logic              idx_rd
);
   logic hit_idx, hit_dat;

   assign port_addr = alt_sel ? ALT_PORT : PRI_PORT;
   assign hit_idx   = (bus_addr == port_addr);
   assign hit_dat   = (bus_addr == port_addr + ADDR_W'(1));
   assign data_wr   = bus_wr & hit_dat & unlocked;
   assign data_rd   = bus_rd & hit_dat;
   assign idx_rd    = bus_rd & hit_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx      <= '0;
         unlocked <= 1'b0;
      end else if (bus_wr && hit_idx) begin
         idx <= bus_wdata;
         if (bus_wdata == KEY_OPEN)
            unlocked <= 1'b1;
         else if (bus_wdata == KEY_CLOSE)
            unlocked <= 1'b0;
      end
   end

   assert_unlock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_idx && bus_wdata == KEY_OPEN) |=> unlocked);
   assert_lock_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && !(bus_wr && hit_idx)) |=> !unlocked);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs import ldev_cfg_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       data_wr,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   input  logic [7:0] port_lo,
   output logic [3:0] ldn,
   output logic [7:0] pwr,
   output logic       soft_rst,
   output logic [7:0] rd_global
);
   logic [7:0] r_srst, r_cfga, r_cfgb;

   assign soft_rst = data_wr && (idx == IX_SRST) && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_srst <= '0;
         ldn    <= '0;
         pwr    <= '0;
         r_cfga <= '0;
         r_cfgb <= CFGB_RST;
      end else if (data_wr) begin
         case (idx)
            IX_SRST: begin
               r_srst <= wdata;
               if (wdata[0]) begin
                  ldn <= '0;
                  pwr <= '0;
               end
            end
            IX_LDN:  ldn    <= wdata[3:0];
            IX_PWR:  pwr    <= wdata & MASK_PWR;
            IX_CFGA: r_cfga <= wdata & MASK_CFGA;
            IX_CFGB: r_cfgb <= wdata & MASK_CFGB;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (idx)
         IX_SRST: rd_global = r_srst;
         IX_LDN:  rd_global = {4'h0, ldn};
         IX_ID:   rd_global = CHIP_ID;
         IX_PWR:  rd_global = pwr;
         IX_CFGA: rd_global = r_cfga;
         IX_CFGB: rd_global = r_cfgb;
         IX_PLO:  rd_global = {4'h0, port_lo[3:0]};
         IX_PHI:  rd_global = {4'h0, port_lo[7:4]};
         default: rd_global = '0;
      endcase
   end

   assert_ldn_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && idx == IX_LDN) |=> (ldn == $past(wdata[3:0])));
   assert_cfgb_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (r_cfgb & ~MASK_CFGB) == 8'h00);
   assert_soft_global_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ldn == 4'h0 && pwr == 8'h00));
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank import ldev_cfg_pkg::*; #(
   parameter logic [3:0]  LDN_CODE = 4'd0,
   parameter logic [15:0] DEF_BASE = 16'h0000,
   parameter logic [7:0]  DEF_IRQ  = 8'h00,
   parameter logic [7:0]  DEF_DMA  = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        soft_rst,
   input  logic        data_wr,
   input  logic [3:0]  ldn,
   input  logic [7:0]  idx,
   input  logic [7:0]  wdata,
   output logic        sel,
   output logic        act,
   output logic [15:0] base,
   output logic [7:0]  irq_b,
   output logic [7:0]  dma_b,
   output logic [7:0]  rd_bank
);
   logic we;

   assign sel = (ldn == LDN_CODE);
   assign we  = data_wr & sel;

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         act   <= 1'b0;
         base  <= DEF_BASE;
         irq_b <= DEF_IRQ;
         dma_b <= DEF_DMA;
      end else if (we) begin
         case (idx)
            IX_ACT: act         <= wdata[0];
            IX_BHI: base[15:8]  <= wdata;
            IX_BLO: base[7:0]   <= wdata;
            IX_IRQ: irq_b       <= wdata;
            IX_DMA: dma_b       <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (idx)
         IX_ACT:  rd_bank = {7'h00, act};
         IX_BHI:  rd_bank = base[15:8];
         IX_BLO:  rd_bank = base[7:0];
         IX_IRQ:  rd_bank = irq_b;
         IX_DMA:  rd_bank = dma_b;
         default: rd_bank = '0;
      endcase
   end

   assert_base_hi_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == IX_BHI && !soft_rst) |=> (base[15:8] == $past(wdata)));
   assert_soft_default_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (base == DEF_BASE && irq_b == DEF_IRQ && dma_b == DEF_DMA && !act));
   assert_other_ldn_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !soft_rst) |=> $stable(base));
endmodule

// File: rtl/ldev_cfg_regs.sv
module ldev_cfg_regs import ldev_cfg_pkg::*; #(
   parameter int ADDR_W = 16,
   parameter int IRQ_W  = 4,
   parameter int DMA_W  = 3,
   parameter logic [ADDR_W-1:0] PRI_PORT = 16'h03F0,
   parameter logic [ADDR_W-1:0] ALT_PORT = 16'h0370
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          alt_port_sel,
   input  logic                          bus_wr,
   input  logic                          bus_rd,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [7:0]                    bus_wdata,
   output logic [7:0]                    bus_rdata,
   output logic [LDEV_COUNT-1:0]         dev_en,
   output logic [LDEV_COUNT*16-1:0]      dev_base,
   output logic [LDEV_COUNT*IRQ_W-1:0]   dev_irq,
   output logic [LDEV_COUNT*DMA_W-1:0]   dev_dma
);
   localparam int NDEV = LDEV_COUNT;

   if (IRQ_W < 1 || IRQ_W > 8) begin : g_bad_irq
      $error("IRQ_W must be 1..8");
   end
   if (DMA_W < 1 || DMA_W > 8) begin : g_bad_dma
      $error("DMA_W must be 1..8");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W too small for the port addresses");
   end

   logic [ADDR_W-1:0] port_addr;
   logic [7:0]        idx, rd_global, rd_banks;
   logic              unlocked, data_wr, data_rd, idx_rd, soft_rst;
   logic [3:0]        ldn;
   logic [7:0]        pwr;
   logic [7:0]        bank_rd_vec [NDEV];
   logic [NDEV-1:0]   act_vec;

   cfg_port_decode #(.ADDR_W(ADDR_W), .PRI_PORT(PRI_PORT), .ALT_PORT(ALT_PORT)) u_dec (
      .clk(clk), .rst_n(rst_n), .alt_sel(alt_port_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .port_addr(port_addr), .idx(idx),
      .unlocked(unlocked), .data_wr(data_wr), .data_rd(data_rd), .idx_rd(idx_rd)
   );

   cfg_global_regs u_glb (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .idx(idx), .wdata(bus_wdata),
      .port_lo(port_addr[7:0]), .ldn(ldn), .pwr(pwr), .soft_rst(soft_rst),
      .rd_global(rd_global)
   );

   for (genvar g = 0; g < NDEV; g++) begin : g_dev
      logic        sel, act;
      logic [15:0] base;
      logic [7:0]  irq_b, dma_b, rd_b;

      cfg_dev_bank #(
         .LDN_CODE(ldn_of(g)), .DEF_BASE(def_base_of(g)),
         .DEF_IRQ(def_irq_of(g)), .DEF_DMA(def_dma_of(g))
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .data_wr(data_wr), .ldn(ldn),
         .idx(idx), .wdata(bus_wdata), .sel(sel), .act(act), .base(base),
         .irq_b(irq_b), .dma_b(dma_b), .rd_bank(rd_b)
      );

      assign dev_base[g*16 +: 16]      = base;
      assign dev_irq[g*IRQ_W +: IRQ_W] = irq_b[IRQ_W-1:0];
      assign dev_dma[g*DMA_W +: DMA_W] = dma_b[DMA_W-1:0];
      assign bank_rd_vec[g]            = sel ? rd_b : 8'h00;
      assign act_vec[g]                = act;

      if (pwr_bit_of(g) >= 0) begin : g_pwr
         assign dev_en[g] = act | pwr[pwr_bit_of(g)];
      end else begin : g_nopwr
         assign dev_en[g] = act;
      end
   end

   always_comb begin
      rd_banks = '0;
      for (int i = 0; i < NDEV; i++)
         rd_banks = rd_banks | bank_rd_vec[i];
   end

   always_comb begin
      if (data_rd)
         bus_rdata = (idx >= IX_BANK) ? rd_banks : rd_global;
      else if (idx_rd)
         bus_rdata = idx;
      else
         bus_rdata = '0;
   end

   assert_locked_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == port_addr + ADDR_W'(1) && !unlocked)
      |=> ($stable(act_vec) && $stable(dev_base) && $stable(dev_irq) && $stable(dev_dma)));
   assert_floppy_pwr_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pwr[0] |-> dev_en[0]);
   assert_parallel_act_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !act_vec[1] |-> !dev_en[1]);
   assert_idle_rdata_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/ldev_cfg_regs_tb.sv
module ldev_cfg_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alt_port_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [3:0]  dev_en;
   logic [63:0] dev_base;
   logic [15:0] dev_irq;
   logic [11:0] dev_dma;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model
   int m_un, m_idx, m_ldn, m_02, m_22, m_23, m_24;
   int m_act [4];
   int m_base[4];
   int m_irq [4];
   int m_dma [4];

   always #2 clk = ~clk;

   ldev_cfg_regs u_dut (
      .clk(clk), .rst_n(rst_n), .alt_port_sel(alt_port_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_en(dev_en),
      .dev_base(dev_base), .dev_irq(dev_irq), .dev_dma(dev_dma)
   );

   function automatic int port();
      return alt_port_sel ? 32'h370 : 32'h3F0;
   endfunction

   function automatic int dev_of(int l);
      case (l)
         0: return 0;
         3: return 1;
         4: return 2;
         5: return 3;
         default: return -1;
      endcase
   endfunction

   task automatic model_banks_default();
      for (int d = 0; d < 4; d++) begin
         m_act[d]  = 0;
         m_base[d] = (d == 0) ? 32'h3F0 : 0;
         m_irq[d]  = (d == 0) ? 6 : 0;
         m_dma[d]  = (d == 0) ? 2 : 0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_un = 0; m_idx = 0; m_ldn = 0; m_02 = 0; m_22 = 0; m_23 = 0; m_24 = 4;
      model_banks_default();
   endtask

   task automatic check(int act, int exp, string req, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(int addr, int data);
      @(negedge clk);
      bus_addr  = addr[15:0];
      bus_wdata = data[7:0];
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      if (addr == port()) begin
         m_idx = data;
         if (data == 8'h55) m_un = 1;
         else if (data == 8'hAA) m_un = 0;
      end else if (addr == port() + 1 && m_un == 1) begin
         int d;
         d = dev_of(m_ldn);
         case (m_idx)
            8'h02: begin
               m_02 = data;
               if (data[0]) begin m_ldn = 0; m_22 = 0; model_banks_default(); end
            end
            8'h07: m_ldn = data & 15;
            8'h22: m_22 = data & 8'h3F;
            8'h23: m_23 = data & 8'h3F;
            8'h24: m_24 = data & 8'hCE;
            8'h30: if (d >= 0) m_act[d] = data & 1;
            8'h60: if (d >= 0) m_base[d] = (m_base[d] & 8'hFF) | (data << 8);
            8'h61: if (d >= 0) m_base[d] = (m_base[d] & 16'hFF00) | data;
            8'h70: if (d >= 0) m_irq[d] = data;
            8'h74: if (d >= 0) m_dma[d] = data;
            default: ;
         endcase
      end
   endtask

   function automatic int exp_reg(int ix);
      int d;
      d = dev_of(m_ldn);
      if (ix >= 8'h30) begin
         if (d < 0) return 0;
         case (ix)
            8'h30: return m_act[d];
            8'h60: return m_base[d] >> 8;
            8'h61: return m_base[d] & 8'hFF;
            8'h70: return m_irq[d];
            8'h74: return m_dma[d];
            default: return 0;
         endcase
      end
      case (ix)
         8'h02: return m_02;
         8'h07: return m_ldn;
         8'h20: return 8'h47;
         8'h22: return m_22;
         8'h23: return m_23;
         8'h24: return m_24;
         8'h26: return port() & 15;
         8'h27: return (port() >> 4) & 15;
         default: return 0;
      endcase
   endfunction

   task automatic rd(int addr, output int val);
      @(negedge clk);
      bus_addr = addr[15:0];
      bus_rd   = 1'b1;
      #1 val   = int'(bus_rdata);
      bus_rd   = 1'b0;
   endtask

   task automatic check_reg(int ix, string req);
      int v;
      wr(port(), ix);
      rd(port() + 1, v);
      check(v, exp_reg(ix), req, $sformatf("reg %0h ldn %0d", ix, m_ldn));
   endtask

   task automatic check_outs(string req);
      @(negedge clk);
      for (int d = 0; d < 4; d++) begin
         int pb, en;
         pb = (d == 0) ? 0 : (d == 2) ? 4 : (d == 3) ? 5 : -1;
         en = m_act[d] | ((pb >= 0) ? ((m_22 >> pb) & 1) : 0);
         check(int'(dev_en[d]), en, req, $sformatf("en slot %0d", d));
         check(int'(dev_base[d*16 +: 16]), m_base[d], req, $sformatf("base slot %0d", d));
         check(int'(dev_irq[d*4 +: 4]), m_irq[d] & 15, req, $sformatf("irq slot %0d", d));
         check(int'(dev_dma[d*3 +: 3]), m_dma[d] & 7, req, $sformatf("dma slot %0d", d));
      end
   endtask

   task automatic check_all_regs(string req);
      int save;
      save = m_ldn;
      foreach (m_act[d]) begin
         int codes[4] = '{0, 3, 4, 5};
         if (m_un == 1) begin
            wr(port(), 8'h07); wr(port() + 1, codes[d]);
            check_reg(8'h30, req); check_reg(8'h60, req); check_reg(8'h61, req);
            check_reg(8'h70, req); check_reg(8'h74, req);
         end
      end
      if (m_un == 1) begin wr(port(), 8'h07); wr(port() + 1, save); end
      check_reg(8'h07, req); check_reg(8'h22, req); check_reg(8'h23, req); check_reg(8'h24, req);
      check_outs(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int v;
      do_reset();

      // R8: reset values (reads work while locked)
      check_outs("R8");
      check_reg(8'h20, "R8"); check_reg(8'h24, "R8"); check_reg(8'h26, "R8");
      check_reg(8'h27, "R8"); check_reg(8'h07, "R8");
      check_reg(8'h30, "R8"); check_reg(8'h60, "R8"); check_reg(8'h61, "R8");
      check_reg(8'h70, "R8"); check_reg(8'h74, "R8");

      // R6: index port read returns index
      wr(port(), 8'h61);
      rd(port(), v);
      check(v, 8'h61, "R6", "index readback");

      // R2: locked after reset, data writes ignored
      wr(port(), 8'h60); wr(port() + 1, 8'h12);
      wr(port(), 8'h07); wr(port() + 1, 8'h04);
      wr(port(), 8'h22); wr(port() + 1, 8'h3F);
      check_reg(8'h60, "R2"); check_reg(8'h07, "R2"); check_outs("R2");

      // R3 R5: unlock, fill each device code with distinct values
      wr(port(), 8'h55);
      for (int l = 0; l < 16; l++) begin
         wr(port(), 8'h07); wr(port() + 1, 8'hF0 | l);
         wr(port(), 8'h30); wr(port() + 1, (l * 3) | 8'h02);
         wr(port(), 8'h60); wr(port() + 1, l * 17 + 1);
         wr(port(), 8'h61); wr(port() + 1, l * 29 + 5);
         wr(port(), 8'h70); wr(port() + 1, l * 37 + 9);
         wr(port(), 8'h74); wr(port() + 1, l * 41 + 3);
      end
      for (int l = 0; l < 16; l++) begin
         wr(port(), 8'h07); wr(port() + 1, l);
         check_reg(8'h07, "R3");
         check_reg(8'h30, "R5"); check_reg(8'h60, "R5"); check_reg(8'h61, "R5");
         check_reg(8'h70, "R5"); check_reg(8'h74, "R5"); check_reg(8'h75, "R6");
      end
      check_outs("R3");

      // R4: mask sweep
      for (int x = 0; x < 256; x++) begin
         wr(port(), 8'h22); wr(port() + 1, x); check_reg(8'h22, "R4");
         wr(port(), 8'h23); wr(port() + 1, x); check_reg(8'h23, "R4");
         wr(port(), 8'h24); wr(port() + 1, x); check_reg(8'h24, "R4");
      end

      // R7: enable from activate or power-control
      for (int d = 0; d < 4; d++) begin
         int codes[4] = '{0, 3, 4, 5};
         wr(port(), 8'h07); wr(port() + 1, codes[d]);
         wr(port(), 8'h30); wr(port() + 1, 0);
      end
      for (int p = 0; p < 64; p++) begin
         wr(port(), 8'h22); wr(port() + 1, p | 8'hC0);
         check_outs("R7");
      end
      wr(port(), 8'h22); wr(port() + 1, 0);
      for (int d = 0; d < 4; d++) begin
         int codes[4] = '{0, 3, 4, 5};
         wr(port(), 8'h07); wr(port() + 1, codes[d]);
         wr(port(), 8'h30); wr(port() + 1, 8'hFF);
         check_outs("R7");
      end

      // R6: global reads of unimplemented index return 0
      check_reg(8'h10, "R6"); check_reg(8'h2F, "R6");

      // R2: lock with key and try every register
      wr(port(), 8'hAA);
      foreach (m_act[i]) begin
         wr(port(), 8'h07); wr(port() + 1, 3);
         wr(port(), 8'h30); wr(port() + 1, 0);
         wr(port(), 8'h60); wr(port() + 1, 8'h99);
         wr(port(), 8'h70); wr(port() + 1, 8'h0B);
         wr(port(), 8'h22); wr(port() + 1, 8'h00);
         wr(port(), 8'h02); wr(port() + 1, 8'h01);
      end
      check_reg(8'h07, "R2"); check_reg(8'h22, "R2"); check_reg(8'h30, "R2");
      check_reg(8'h60, "R2"); check_reg(8'h02, "R2"); check_outs("R2");

      // R1: writes to neighbouring/other addresses ignored
      wr(port() + 2, 8'h55);
      wr(16'h0371, 8'h00);
      wr(port(), 8'h07);
      wr(port() + 1, 8'h05);
      check_reg(8'h07, "R1");
      rd(port() + 2, v);
      check(v, 0, "R1", "read of other address");

      // R9: soft reset
      wr(port(), 8'h55);
      wr(port(), 8'h07); wr(port() + 1, 4);
      wr(port(), 8'h22); wr(port() + 1, 8'h31);
      wr(port(), 8'h23); wr(port() + 1, 8'h15);
      wr(port(), 8'h02); wr(port() + 1, 8'h03);
      check_all_regs("R9");
      check_reg(8'h02, "R9");
      wr(port(), 8'h07); wr(port() + 1, 5);
      check_reg(8'h07, "R9");

      // R1 R8: alternate strap
      alt_port_sel = 1'b1;
      do_reset();
      check_reg(8'h26, "R8"); check_reg(8'h27, "R8");
      wr(16'h03F0, 8'h55); wr(16'h03F0, 8'h07); wr(16'h03F1, 8'h04);
      wr(port(), 8'h07); wr(port() + 1, 8'h04);
      check_reg(8'h07, "R1");
      wr(port(), 8'h55);
      wr(port(), 8'h07); wr(port() + 1, 8'h04);
      wr(port(), 8'h61); wr(port() + 1, 8'hE8);
      check_reg(8'h07, "R1"); check_reg(8'h61, "R1");
      check_outs("R1");

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule